// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block guards loads that a compiler has moved above earlier stores. When such a hoisted load issues, it records the 8-byte granule of its address in a small fully associative table, keyed by its destination register number. Every store that follows is compared against all live entries, and any entry whose granule it touches is dropped. At the spot where the load used to sit, a check operation names the same register. If a live entry for that register is found, the speculative value stands. If none is found, the load must be done again. Replaying the load is left to the surrounding pipeline.

Each cycle the table accepts one load record, one store snoop and one check, all at once. A check consumes its entry. When the table is full, a record for a new register displaces the entry recorded longest ago. A later check for the displaced register then asks for a replay, which is always safe. Same-cycle events are resolved in a fixed program order: a store sharing a cycle with a record is older than that record, and a store or a record sharing a cycle with a check is ordered as described in the requirements.

Top module: `spec_load_table`

## Requirements
- R1: While rst_n is low and on the first cycle after it, rsp_valid, rsp_hit and rsp_reexec are 0. After reset the table holds no entries, so any check answers re-execute.
- R2: A check on chk_reg gives rsp_valid=1 on the next cycle. It gives rsp_hit=1 when a live entry for that register exists and no store in the same cycle touches its granule. Otherwise it gives rsp_reexec=1.
- R3: A granule is address bits [ADDR_W-1:3]. A store whose granule equals an entry's granule drops that entry, so a later check for it answers re-execute. A store to any other granule leaves the entry live.
- R4: A check drops the entry it finds. A second check on the same register with no new record in between answers re-execute.
- R5: A record for a register that already has a live entry replaces that entry's address. At most one live entry exists per register. A store to the old address no longer affects it.
- R6: When all ENTRIES entries are live, a record for a register without an entry evicts the entry recorded least recently. A re-record counts as a fresh recording. The evicted register's next check answers re-execute, and the other entries remain live.
- R7: A record and a store to the same granule in the same cycle leave the new entry live.
- R8: A check and a store to its entry's granule in the same cycle answer re-execute.
- R9: A check and a record for the same register in the same cycle are answered from the earlier entry, and the new record stays live.
- R10: rsp_valid is high exactly in the cycle after each chk_valid cycle. Whenever rsp_valid is high, exactly one of rsp_hit and rsp_reexec is high. Both are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Record a hoisted load this cycle |
| ld_reg | input | REG_W | Destination register of the hoisted load |
| ld_addr | input | ADDR_W | Byte address of the hoisted load |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_reg | input | REG_W | Register whose entry is checked |
| rsp_valid | output | 1 | Check answer present (one cycle after chk_valid) |
| rsp_hit | output | 1 | Speculative value may be kept |
| rsp_reexec | output | 1 | Load must be executed again |

## Verification
A wrong entry state shows only through check answers. A missed store kill or a wrong victim turns a required re-execute into a hit, and a spurious kill turns a hit into a re-execute. Each appears on the rsp_* pins one cycle after the first check of the affected register, and not before. The bench therefore follows every record with a check. Its reference model tracks entries as an ordered list, and it compares the answer pins every cycle under directed same-cycle collisions and a long random mix that forces frequent evictions.

// File: rtl/slt_pkg.sv
package slt_pkg;

  // Registered answer of a check operation.
  typedef enum logic [1:0] {
    RSP_IDLE   = 2'd0,
    RSP_HIT    = 2'd1,
    RSP_REEXEC = 2'd2
  } rsp_e;

  // A check without a live, unkilled entry must be replayed.
  function automatic rsp_e classify(logic chk, logic found);
    if (!chk) return RSP_IDLE;
    return found ? RSP_HIT : RSP_REEXEC;
  endfunction

endpackage

// File: rtl/slt_entry.sv
module slt_entry #(
  parameter int REG_W  = 7,
  parameter int GRAN_W = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [GRAN_W-1:0] ld_gran,
  input  logic              st_valid,
  input  logic [GRAN_W-1:0] st_gran,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              valid_o,
  output logic              st_hit_o,
  output logic              chk_match_o,
  output logic              ld_match_o
);

  logic              valid_q;
  logic [REG_W-1:0]  reg_q;
  logic [GRAN_W-1:0] gran_q;

  assign st_hit_o    = valid_q && st_valid && (gran_q == st_gran);
  assign chk_match_o = valid_q && chk_valid && (reg_q == chk_reg);
  assign ld_match_o  = valid_q && (reg_q == ld_reg);
  assign valid_o     = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      reg_q   <= '0;
      gran_q  <= '0;
    end else if (wr_en) begin
      // a record is younger than any store or check in its cycle
      valid_q <= 1'b1;
      reg_q   <= ld_reg;
      gran_q  <= ld_gran;
    end else if (st_hit_o || chk_match_o) begin
      valid_q <= 1'b0;
    end
  end

  assert_record_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_o);
  assert_store_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit_o && !wr_en) |=> !valid_o);
  assert_check_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_match_o && !wr_en) |=> !valid_o);

endmodule

// File: rtl/slt_age.sv
module slt_age #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [N-1:0] alloc_oh,
  output logic [N-1:0] oldest_oh
);

  // older_q[i][j] set: slot i was recorded before slot j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else if (alloc_en) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j) begin
            if (alloc_oh[i])      older_q[i][j] <= 1'b0;
            else if (alloc_oh[j]) older_q[i][j] <= 1'b1;
          end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_oldest
    localparam logic [N-1:0] SELF = {{(N-1){1'b0}}, 1'b1} << g;
    assign oldest_oh[g] = &(older_q[g] | SELF);
  end

  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_oh));

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid_vec,
  input  logic [N-1:0] same_vec,
  input  logic [N-1:0] oldest_oh,
  output logic [N-1:0] slot_oh
);

  logic [N-1:0] free_oh;
  logic         seen;
  logic         full;

  always_comb begin
    free_oh = '0;
    seen    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid_vec[i] && !seen) begin
        free_oh[i] = 1'b1;
        seen       = 1'b1;
      end
    end
  end

  assign full = &valid_vec;

  // same register first, then lowest free slot, then the oldest entry
  always_comb begin
    if (|same_vec) slot_oh = same_vec;
    else if (full) slot_oh = oldest_oh;
    else           slot_oh = free_oh;
  end

  assert_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(slot_oh));
  assert_evict_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !(|same_vec)) |-> ((slot_oh & valid_vec) == '0));

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int REG_W      = 7,
  parameter int ADDR_W     = 48,
  parameter int GRAN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_reexec
);

  localparam int GRAN_LSB = $clog2(GRAN_BYTES);
  localparam int GRAN_W   = ADDR_W - GRAN_LSB;

  logic [GRAN_W-1:0]  ld_gran;
  logic [GRAN_W-1:0]  st_gran;
  logic [ENTRIES-1:0] entry_valid;
  logic [ENTRIES-1:0] entry_st_hit;
  logic [ENTRIES-1:0] entry_chk_match;
  logic [ENTRIES-1:0] entry_ld_match;
  logic [ENTRIES-1:0] slot_oh;
  logic [ENTRIES-1:0] oldest_oh;
  logic               lookup_found;
  rsp_e               rsp_q;
  logic               unused_low_bits;

  assign ld_gran = ld_addr[ADDR_W-1:GRAN_LSB];
  assign st_gran = st_addr[ADDR_W-1:GRAN_LSB];
  assign unused_low_bits = ^{ld_addr[GRAN_LSB-1:0], st_addr[GRAN_LSB-1:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    slt_entry #(.REG_W(REG_W), .GRAN_W(GRAN_W)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ld_valid && slot_oh[e]),
      .ld_reg      (ld_reg),
      .ld_gran     (ld_gran),
      .st_valid    (st_valid),
      .st_gran     (st_gran),
      .chk_valid   (chk_valid),
      .chk_reg     (chk_reg),
      .valid_o     (entry_valid[e]),
      .st_hit_o    (entry_st_hit[e]),
      .chk_match_o (entry_chk_match[e]),
      .ld_match_o  (entry_ld_match[e])
    );
  end

  slt_age #(.N(ENTRIES)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (ld_valid),
    .alloc_oh  (slot_oh),
    .oldest_oh (oldest_oh)
  );

  slt_alloc #(.N(ENTRIES)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (entry_valid),
    .same_vec  (entry_ld_match),
    .oldest_oh (oldest_oh),
    .slot_oh   (slot_oh)
  );

  // a store in the check's cycle is older than the check
  assign lookup_found = |(entry_chk_match & ~entry_st_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_q <= RSP_IDLE;
    else        rsp_q <= classify(chk_valid, lookup_found);
  end

  assign rsp_valid  = (rsp_q != RSP_IDLE);
  assign rsp_hit    = (rsp_q == RSP_HIT);
  assign rsp_reexec = (rsp_q == RSP_REEXEC);

  assert_rsp_follows_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);
  assert_no_stray_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid);
  assert_rsp_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_reexec));
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_reexec));
  assert_one_entry_per_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(entry_ld_match) <= 1);
  assert_hit_needs_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $past(|entry_chk_match));
  assert_store_forces_replay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(entry_chk_match & entry_st_hit)) |=> rsp_reexec);

endmodule

// File: tb/spec_load_table_bench.sv
module spec_load_table_bench;

  localparam int E  = 8;
  localparam int RW = 7;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, st_valid, chk_valid;
  logic [RW-1:0] ld_reg, chk_reg;
  logic [AW-1:0] ld_addr, st_addr;
  logic          rsp_valid, rsp_hit, rsp_reexec;

  int checks = 0;
  int errors = 0;

  // reference: live entries, oldest recording first
  int     q_reg[$];
  longint q_gran[$];
  logic   exp_v, exp_h;

  always #4 clk = ~clk;

  spec_load_table u_spec_load_table (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_reexec(rsp_reexec)
  );

  task automatic drop_reg(int r);
    for (int i = q_reg.size() - 1; i >= 0; i--)
      if (q_reg[i] == r) begin
        q_reg.delete(i);
        q_gran.delete(i);
      end
  endtask

  task automatic step(string tag, bit li, int lr, longint la,
                      bit si, longint sa, bit ci, int cr);
    bit found;
    bit has_ld;
    int victim;
    @(negedge clk);
    ld_valid = li; ld_reg = RW'(lr); ld_addr = la[AW-1:0];
    st_valid = si; st_addr = sa[AW-1:0];
    chk_valid = ci; chk_reg = RW'(cr);
    found = 0; has_ld = 0; victim = -1;
    for (int i = 0; i < q_reg.size(); i++) begin
      if (ci && q_reg[i] == cr && !(si && q_gran[i] == (sa >> 3))) found = 1;
      if (q_reg[i] == lr) has_ld = 1;
    end
    if (li && !has_ld && q_reg.size() == E) victim = q_reg[0];
    for (int i = q_reg.size() - 1; i >= 0; i--)
      if (si && q_gran[i] == (sa >> 3)) begin
        q_reg.delete(i);
        q_gran.delete(i);
      end
    if (ci) drop_reg(cr);
    if (li) begin
      drop_reg(lr);
      if (victim >= 0) drop_reg(victim);
      q_reg.push_back(lr);
      q_gran.push_back(la >> 3);
    end
    exp_v = ci;
    exp_h = ci && found;
    @(posedge clk);
    #2;
    checks++;
    if (rsp_valid !== exp_v || rsp_hit !== exp_h || rsp_reexec !== (exp_v && !exp_h)) begin
      errors++;
      $display("FAIL %s: got v/h/r=%b%b%b expected %b%b%b", tag,
               rsp_valid, rsp_hit, rsp_reexec, exp_v, exp_h, exp_v && !exp_h);
    end
  endtask

  // literal expectation from the requirement, independent of the model
  task automatic expect_hit(string tag, bit want);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== want) begin
      errors++;
      $display("FAIL %s: got valid=%b hit=%b expected valid=1 hit=%b",
               tag, rsp_valid, rsp_hit, want);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 0; st_valid = 0; chk_valid = 0;
    ld_reg = '0; chk_reg = '0; ld_addr = '0; st_addr = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_reexec !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v/h/r=%b%b%b expected 000", rsp_valid, rsp_hit, rsp_reexec);
    end
    rst_n = 1'b1;
    // R1: empty table answers re-execute
    step("R1", 0, 0, 0, 0, 0, 1, 5);          expect_hit("R1", 0);
    // R2: record then check
    step("R2", 1, 1, 'h1000, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 1);          expect_hit("R2", 1);
    // R3: same-granule store kills, neighbouring granule does not
    step("R3", 1, 2, 'h2000, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 'h2007, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 2);          expect_hit("R3", 0);
    step("R3", 1, 3, 'h3000, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 'h3008, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 3);          expect_hit("R3", 1);
    // R4: a check consumes its entry
    step("R4", 1, 4, 'h4000, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 4);          expect_hit("R4", 1);
    step("R4", 0, 0, 0, 0, 0, 1, 4);          expect_hit("R4", 0);
    // R5: re-record moves the address
    step("R5", 1, 5, 'h5000, 0, 0, 0, 0);
    step("R5", 1, 5, 'h6000, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 'h5000, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 5);          expect_hit("R5", 1);
    step("R5", 1, 5, 'h7000, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 'h7004, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 5);          expect_hit("R5", 0);
    // R6: fill, re-record reg 10 so 11 becomes oldest, then overflow
    for (int r = 10; r < 10 + E; r++) step("R6", 1, r, longint'(r) << 8, 0, 0, 0, 0);
    step("R6", 1, 10, 'h9900, 0, 0, 0, 0);
    step("R6", 1, 40, 'h4400, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1, 11);         expect_hit("R6", 0);
    step("R6", 0, 0, 0, 0, 0, 1, 10);         expect_hit("R6", 1);
    step("R6", 0, 0, 0, 0, 0, 1, 40);         expect_hit("R6", 1);
    step("R6", 0, 0, 0, 0, 0, 1, 12);         expect_hit("R6", 1);
    // R7: record and same-granule store together
    step("R7", 1, 30, 'h9000, 1, 'h9000, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 30);         expect_hit("R7", 1);
    // R8: check and killing store together
    step("R8", 1, 31, 'hA000, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 'hA001, 1, 31);    expect_hit("R8", 0);
    // R9: check and re-record of the same register together
    step("R9", 1, 32, 'hB000, 0, 0, 0, 0);
    step("R9", 1, 32, 'hC000, 0, 0, 1, 32);   expect_hit("R9", 1);
    step("R9", 0, 0, 0, 0, 0, 1, 32);         expect_hit("R9", 1);
    // R10: random mix compared against the model every cycle
    for (int n = 0; n < 3000; n++)
      step("R10", bit'($urandom % 2), int'($urandom % 12),
           longint'(($urandom % 16) * 8 + ($urandom % 8)),
           bit'($urandom % 3 == 0), longint'(($urandom % 16) * 8 + ($urandom % 8)),
           bit'($urandom % 2), int'($urandom % 12));
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule